// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block is the message-signalled interrupt engine of a PCIe function with a configurable number of vectors. It keeps, for every vector, a 64-bit target address, a 32-bit payload and a per-vector mask flag. It also keeps a read-only array of pending flags and the two writable control bits of the capability, enable and function-wide mask. Software reaches the table and the pending array through 32-bit register accesses and reaches the control bits through a single byte write. Decoding configuration space and placing the windows in memory are done elsewhere.

Device logic raises interrupts by presenting a vector number. A request that targets a live, unmasked vector becomes one memory-write message, which leaves on a valid/ready handshake. A request that targets a masked vector is parked as a pending flag. The parked request is sent on its own once the vector becomes unmasked. Device logic also keeps a use count per vector, and requests on vectors that are not in use are discarded. When several vectors are ready to send at once, they drain lowest number first, one per accepted handshake.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Each vector owns a 16-byte slot in the table window. The 32-bit word at slot offset 0 is the low address, offset 4 is the high address, offset 8 is the payload, and offset 12 is vector control. Only bit 0 of vector control (the mask) is stored, and its other bits read as zero.
- R2: A table or pending access is rejected, with `reg_err` high and nothing written, when its size is not 4 bytes, when its address is not 4-byte aligned, or when it falls beyond the last vector slot or the last pending word.
- R3: The pending flag of vector v reads at bit (v mod 32) of pending word (v / 32), which is the same as bit (v mod 8) of byte (v / 8). The pending window holds two words for every started group of 64 vectors. Writes to it change nothing.
- R4: In a control byte write, bit 7 is enable and bit 6 is function mask, and the other bits are discarded. `ctl_rdata` shows enable at bit 15, function mask at bit 14 and N-1 in bits 10:0.
- R5: A vector counts as masked when enable is clear, when function mask is set, or when its own mask bit is set. A request on a masked vector sets its pending flag and emits no message.
- R6: A request on an unmasked, in-use vector emits one message whose address is {high, low} and whose data is the payload. `msg_valid` rises at the second clock edge after the request edge.
- R7: A request whose vector number is N or more, or whose vector has a use count of zero, is discarded. It sets no pending flag and sends no message.
- R8: When a vector goes from masked to unmasked, whether through a table write or a control write, and its pending flag is set, the flag clears and the message is sent.
- R9: Use counts rise on `use_inc` and fall on `use_dec`. Falling to zero clears that vector's pending flag. A decrement at zero leaves the count at zero.
- R10: A control write with bit 7 set pulses `intx_clr` for one cycle after the write edge. A control write with bit 7 clear leaves `intx_clr` low.
- R11: Vectors that are ready to send together leave in ascending vector order, one per accepted handshake. The message holds steady while `msg_valid` is high and `msg_ready` is low.
- R12: After reset, every table word reads zero except the mask bits, which are all set. All pending flags, enable and function mask are clear, and no message is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the table window, 1 selects the pending window |
| reg_addr | input | ADDR_W | Byte address within the selected window |
| reg_size | input | 3 | Access size in bytes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when the access is rejected |
| reg_err | output | 1 | Access rejected |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| ctl_rdata | output | 16 | Message control word |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | IDX_W+1 | Requested vector number |
| use_inc | input | 1 | Raise use count of `use_vec` |
| use_dec | input | 1 | Lower use count of `use_vec` |
| use_vec | input | IDX_W+1 | Vector whose use count changes |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| intx_clr | output | 1 | One-cycle request to drop the legacy interrupt line |

## Verification
The assertions assume that `msg_ready` is only used as a handshake: the consumer may stall for as long as it likes, but it never expects the message to change while it is stalled. They also assume that `use_vec` and `req_vec` carry meaningful numbers only when their strobes are high. The bench drives one request, one use-count change or one register access at a time, well away from the clock edge. It lets every message drain before it moves to the next scenario, except in the ordering scenario, where it deliberately holds `msg_ready` low to stall the queue.

// File: rtl/msix_pkg.sv
`timescale 1ns/1ps
// Shared types for the MSI-X controller: the outgoing message and the
// word selector inside one 16-byte vector slot.
package msix_pkg;
    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msix_msg_t;

    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_VCTL    = 2'd3
    } msix_word_e;
endpackage

// File: rtl/msix_ctl.sv
`timescale 1ns/1ps
// Control bits of the capability: enable and function-wide mask.
// Assumes the byte written is byte 1 of the message control word.
module msix_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_byte,
    output logic       fn_mask,
    output logic       intx_clr
);
    localparam logic [7:0] WMASK = 8'hC0;

    logic [7:0] ctl_q;
    logic       intx_q;

    // Keep the writable bits and flag a legacy-line drop on enabling writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            intx_q <= 1'b0;
        end else begin
            intx_q <= wr & wdata[7];
            if (wr) ctl_q <= wdata & WMASK;
        end
    end

    assign ctl_byte = ctl_q;
    assign fn_mask  = ~ctl_q[7] | ctl_q[6];
    assign intx_clr = intx_q;

    AST_INTX_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        intx_clr |-> ctl_byte[7]); // R10
endmodule

// File: rtl/msix_vec_table.sv
`timescale 1ns/1ps
// Vector table storage: address, payload and mask flag per vector.
// Assumes the caller only asserts wr_en for an in-range, checked access.
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  msix_word_e         wr_word,
    input  logic [31:0]        wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  msix_word_e         rd_word,
    output logic [31:0]        rd_data,
    output logic [NUM_VEC-1:0] vmask,
    output msix_msg_t          ent_msg [NUM_VEC]
);
    logic [31:0]        lo_q [NUM_VEC];
    logic [31:0]        hi_q [NUM_VEC];
    logic [31:0]        dat_q [NUM_VEC];
    logic [NUM_VEC-1:0] mask_q;

    // Reset clears every slot and masks every vector; writes update one word.
    always_ff @(posedge clk) begin
        for (int v = 0; v < NUM_VEC; v++) begin
            if (!rst_n) begin
                lo_q[v]   <= '0;
                hi_q[v]   <= '0;
                dat_q[v]  <= '0;
                mask_q[v] <= 1'b1;
            end else if (wr_en && wr_idx == IDX_W'(v)) begin
                case (wr_word)
                    W_ADDR_LO: lo_q[v]   <= wr_data;
                    W_ADDR_HI: hi_q[v]   <= wr_data;
                    W_DATA:    dat_q[v]  <= wr_data;
                    default:   mask_q[v] <= wr_data[0];
                endcase
            end
        end
    end

    // Read one word of the selected slot.
    always_comb begin
        case (rd_word)
            W_ADDR_LO: rd_data = lo_q[rd_idx];
            W_ADDR_HI: rd_data = hi_q[rd_idx];
            W_DATA:    rd_data = dat_q[rd_idx];
            default:   rd_data = {31'd0, mask_q[rd_idx]};
        endcase
    end

    // Present every slot as a ready-made message.
    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            ent_msg[v] = '{addr: {hi_q[v], lo_q[v]}, data: dat_q[v]};
        end
    end

    assign vmask = mask_q;

    AST_MASKED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> &vmask); // R12
endmodule

// File: rtl/msix_use_cnt.sv
`timescale 1ns/1ps
// Per-vector use counters kept by device logic. A counter saturates at
// both ends; reaching zero through a decrement signals a pending release.
module msix_use_cnt #(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               dec,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_VEC-1:0] in_use,
    output logic [NUM_VEC-1:0] release_v
);
    logic [CNT_W-1:0] cnt [NUM_VEC];

    // Step the selected counter, never wrapping.
    always_ff @(posedge clk) begin
        for (int v = 0; v < NUM_VEC; v++) begin
            if (!rst_n) begin
                cnt[v] <= '0;
            end else if (idx == IDX_W'(v)) begin
                if (inc && !dec && cnt[v] != '1)      cnt[v] <= cnt[v] + 1'b1;
                else if (dec && !inc && cnt[v] != '0) cnt[v] <= cnt[v] - 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        assign in_use[g]    = cnt[g] != '0;
        assign release_v[g] = dec & ~inc & (idx == IDX_W'(g)) & (cnt[g] == CNT_W'(1));

        AST_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (dec && !inc && idx == IDX_W'(g) && cnt[g] == '0) |=> cnt[g] == '0); // R9
    end
endmodule

// File: rtl/msix_sched.sv
`timescale 1ns/1ps
// Pending flags, send queue and message output register. Assumes vmask is
// the effective mask and req_hit only flags live, in-use vectors.
module msix_sched
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] vmask,
    input  logic [NUM_VEC-1:0] req_hit,
    input  logic [NUM_VEC-1:0] pend_drop,
    input  msix_msg_t          ent_msg [NUM_VEC],
    input  logic               msg_ready,
    output logic [NUM_VEC-1:0] pend,
    output logic               msg_valid,
    output msix_msg_t          msg_out
);
    logic [NUM_VEC-1:0] mask_q, sendq, unmask, pick_oh;
    logic [IDX_W-1:0]   pick;
    logic               load;

    assign unmask = mask_q & ~vmask & pend;
    assign load   = (~msg_valid | msg_ready) & (|sendq);

    // Choose the lowest queued vector.
    always_comb begin
        pick = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (sendq[v]) pick = IDX_W'(v);
        end
    end
    assign pick_oh = load ? (NUM_VEC'(1) << pick) : '0;

    // Track masks, park masked requests and queue sendable vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            pend   <= '0;
            sendq  <= '0;
        end else begin
            mask_q <= vmask;
            pend   <= (pend & ~unmask & ~pend_drop) | (req_hit & vmask);
            sendq  <= (sendq & ~pick_oh) | unmask | (req_hit & ~vmask);
        end
    end

    // Offer one message at a time, holding it until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_out   <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_out   <= ent_msg[pick];
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_out))); // R11
    AST_PEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(vmask)) == '0)); // R5
endmodule

// File: rtl/msix_vec_ctrl.sv
`timescale 1ns/1ps
// MSI-X controller top: access decode for the table and pending windows,
// request filtering and wiring of control, table, counters and scheduler.
// Assumes NUM_VEC is between 2 and 2048 and ADDR_W covers both windows.
module msix_vec_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int CNT_W   = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(NUM_VEC),
    localparam int REQ_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [2:0]        reg_size,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [15:0]       ctl_rdata,
    input  logic              req_valid,
    input  logic [REQ_W-1:0]  req_vec,
    input  logic              use_inc,
    input  logic              use_dec,
    input  logic [REQ_W-1:0]  use_vec,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data,
    output logic              intx_clr
);
    localparam int PBA_WORDS = ((NUM_VEC + 63) / 64) * 2;
    localparam int PW_W      = $clog2(PBA_WORDS);

    logic [ADDR_W-5:0]         ent_full;
    logic [ADDR_W-3:0]         pw_full;
    logic                      shape_ok, range_ok, acc_ok;
    logic [31:0]               tbl_word, pba_word;
    logic [PBA_WORDS*32-1:0]   pend_pad;
    logic [7:0]                ctl_byte;
    logic                      fn_mask, use_ok, req_ok;
    logic [NUM_VEC-1:0]        vmask, vmask_eff, in_use, release_v, req_hit, pend;
    msix_msg_t                 ent_msg [NUM_VEC];
    msix_msg_t                 msg_out;

    // Classify the register access.
    assign ent_full = reg_addr[ADDR_W-1:4];
    assign pw_full  = reg_addr[ADDR_W-1:2];
    assign shape_ok = (reg_size == 3'd4) && (reg_addr[1:0] == 2'b00);
    assign range_ok = reg_sel ? (pw_full < (ADDR_W-2)'(PBA_WORDS))
                              : (ent_full < (ADDR_W-4)'(NUM_VEC));
    assign acc_ok   = shape_ok & range_ok;
    assign reg_err  = (reg_wr | reg_rd) & ~acc_ok;

    // Pick the read word from the pending flags.
    assign pend_pad  = (PBA_WORDS*32)'(pend);
    assign pba_word  = pend_pad[{pw_full[PW_W-1:0], 5'd0} +: 32];
    assign reg_rdata = (reg_rd && acc_ok) ? (reg_sel ? pba_word : tbl_word) : 32'd0;
    assign ctl_rdata = {ctl_byte, 8'd0} | 16'(NUM_VEC - 1);

    // Filter use-count updates and interrupt requests.
    assign use_ok = use_vec < REQ_W'(NUM_VEC);
    assign req_ok = req_valid && (req_vec < REQ_W'(NUM_VEC));
    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            req_hit[v] = req_ok && (req_vec[IDX_W-1:0] == IDX_W'(v)) && in_use[v];
        end
    end
    assign vmask_eff = vmask | {NUM_VEC{fn_mask}};

    msix_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .ctl_byte(ctl_byte), .fn_mask(fn_mask), .intx_clr(intx_clr)
    );

    msix_vec_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr & acc_ok & ~reg_sel), .wr_idx(ent_full[IDX_W-1:0]),
        .wr_word(msix_word_e'(reg_addr[3:2])), .wr_data(reg_wdata),
        .rd_idx(ent_full[IDX_W-1:0]), .rd_word(msix_word_e'(reg_addr[3:2])),
        .rd_data(tbl_word), .vmask(vmask), .ent_msg(ent_msg)
    );

    msix_use_cnt #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_use (
        .clk(clk), .rst_n(rst_n), .inc(use_inc & use_ok), .dec(use_dec & use_ok),
        .idx(use_vec[IDX_W-1:0]), .in_use(in_use), .release_v(release_v)
    );

    msix_sched #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .vmask(vmask_eff), .req_hit(req_hit),
        .pend_drop(release_v), .ent_msg(ent_msg), .msg_ready(msg_ready),
        .pend(pend), .msg_valid(msg_valid), .msg_out(msg_out)
    );

    assign msg_addr = msg_out.addr;
    assign msg_data = msg_out.data;

    AST_BAD_SIZE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && reg_size != 3'd4) |-> reg_err); // R2
endmodule

// File: tb/msix_vec_ctrl_bench.sv
`timescale 1ns/1ps
module msix_vec_ctrl_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0, reg_sel = 0;
    logic [11:0] reg_addr = '0;
    logic [2:0]  reg_size = 3'd4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic        ctl_wr = 0;
    logic [7:0]  ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        req_valid = 0;
    logic [3:0]  req_vec = '0;
    logic        use_inc = 0, use_dec = 0;
    logic [3:0]  use_vec = '0;
    logic        msg_valid, msg_ready = 0;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        intx_clr;

    int checks = 0;
    int errs = 0;

    always #2.5 clk = ~clk;

    msix_vec_ctrl u_msix_vec_ctrl (.*);

    function automatic logic [31:0] e_lo(int v);  return 32'hA000_0000 + (v << 4); endfunction
    function automatic logic [31:0] e_hi(int v);  return 32'h0000_0100 + v;        endfunction
    function automatic logic [31:0] e_dat(int v); return 32'hD0D0_0000 + v * 3;    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(logic sel, logic [11:0] a, logic [31:0] d, logic [2:0] sz);
        reg_wr = 1; reg_sel = sel; reg_addr = a; reg_wdata = d; reg_size = sz;
        step();
        reg_wr = 0; reg_size = 3'd4;
    endtask

    task automatic rd_reg(logic sel, logic [11:0] a, logic [2:0] sz,
                          output logic [31:0] d, output logic e);
        reg_rd = 1; reg_sel = sel; reg_addr = a; reg_size = sz;
        #1;
        d = reg_rdata; e = reg_err;
        reg_rd = 0; reg_size = 3'd4;
        #0.5;
    endtask

    task automatic ctl(logic [7:0] b);
        ctl_wr = 1; ctl_wdata = b;
        step();
        ctl_wr = 0;
    endtask

    task automatic req(logic [3:0] v);
        req_valid = 1; req_vec = v;
        step();
        req_valid = 0;
    endtask

    task automatic use_step(logic [3:0] v, bit up);
        use_vec = v; use_inc = up; use_dec = !up;
        step();
        use_inc = 0; use_dec = 0;
    endtask

    task automatic expect_msg(int v, string tag);
        for (int i = 0; i < 16 && !msg_valid; i++) step();
        check(msg_valid, {tag, " valid"}, 64'(msg_valid), 64'd1);
        check(msg_addr == {e_hi(v), e_lo(v)}, {tag, " address"}, msg_addr, {e_hi(v), e_lo(v)});
        check(msg_data == e_dat(v), {tag, " data"}, 64'(msg_data), 64'(e_dat(v)));
        msg_ready = 1;
        step();
        msg_ready = 0;
    endtask

    task automatic expect_quiet(string tag);
        for (int i = 0; i < 4; i++) step();
        check(!msg_valid, {tag, " no message"}, 64'(msg_valid), 64'd0);
    endtask

    task automatic check_pend(logic [31:0] exp, string tag);
        logic [31:0] d; logic e;
        rd_reg(1'b1, 12'h000, 3'd4, d, e);
        check(d == exp && !e, {tag, " pending word"}, 64'(d), 64'(exp));
    endtask

    task automatic check_reset_state(string tag);
        logic [31:0] d; logic e;
        for (int v = 0; v < N; v++) begin
            for (int w = 0; w < 4; w++) begin
                rd_reg(1'b0, 12'(v * 16 + w * 4), 3'd4, d, e);
                check(d == ((w == 3) ? 32'd1 : 32'd0) && !e, {tag, " R12 table word"},
                      64'(d), (w == 3) ? 64'd1 : 64'd0);
            end
        end
        check_pend(32'd0, {tag, " R12"});
        check(ctl_rdata == 16'(N - 1), {tag, " R12 control word"}, 64'(ctl_rdata), 64'(N - 1));
        check(!msg_valid, {tag, " R12 idle output"}, 64'(msg_valid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL all: watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d, d0;
        logic        e;
        logic [63:0] held;

        step(); step();
        rst_n = 1;
        step();
        check_reset_state("first reset");

        // R1: fill every slot and read it back; only the mask bit is kept
        for (int v = 0; v < N; v++) begin
            wr_reg(1'b0, 12'(v * 16 + 0), e_lo(v), 3'd4);
            wr_reg(1'b0, 12'(v * 16 + 4), e_hi(v), 3'd4);
            wr_reg(1'b0, 12'(v * 16 + 8), e_dat(v), 3'd4);
            wr_reg(1'b0, 12'(v * 16 + 12), 32'hFFFF_FFFE, 3'd4);
        end
        for (int v = 0; v < N; v++) begin
            rd_reg(1'b0, 12'(v * 16 + 0), 3'd4, d, e);
            check(d == e_lo(v), "R1 low address", 64'(d), 64'(e_lo(v)));
            rd_reg(1'b0, 12'(v * 16 + 4), 3'd4, d, e);
            check(d == e_hi(v), "R1 high address", 64'(d), 64'(e_hi(v)));
            rd_reg(1'b0, 12'(v * 16 + 8), 3'd4, d, e);
            check(d == e_dat(v), "R1 payload", 64'(d), 64'(e_dat(v)));
            rd_reg(1'b0, 12'(v * 16 + 12), 3'd4, d, e);
            check(d == 32'd0, "R1 vector control", 64'(d), 64'd0);
        end

        // R2: bad size, misaligned, beyond the table and beyond the pending window
        for (int sz = 0; sz < 8; sz++) begin
            if (sz != 4) begin
                wr_reg(1'b0, 12'h008, 32'h1234_5678, 3'(sz));
                rd_reg(1'b0, 12'h008, 3'(sz), d, e);
                check(e == 1'b1 && d == 32'd0, "R2 size rejected", 64'(e), 64'd1);
            end
        end
        wr_reg(1'b0, 12'h00A, 32'h1234_5678, 3'd4);
        rd_reg(1'b0, 12'h00A, 3'd4, d, e);
        check(e == 1'b1, "R2 misaligned rejected", 64'(e), 64'd1);
        rd_reg(1'b0, 12'h008, 3'd4, d, e);
        check(d == e_dat(0) && !e, "R2 rejected writes left payload", 64'(d), 64'(e_dat(0)));
        rd_reg(1'b0, 12'(N * 16), 3'd4, d, e);
        check(e == 1'b1, "R2 slot beyond table", 64'(e), 64'd1);
        rd_reg(1'b1, 12'h008, 3'd4, d, e);
        check(e == 1'b1, "R2 word beyond pending window", 64'(e), 64'd1);
        rd_reg(1'b1, 12'h004, 3'd4, d, e);
        check(e == 1'b0 && d == 32'd0, "R3 second pending word exists", 64'(e), 64'd0);

        // R3: pending window ignores writes
        wr_reg(1'b1, 12'h000, 32'hFFFF_FFFF, 3'd4);
        check_pend(32'd0, "R3 write ignored");

        // R4 and R10: control bits and legacy-line pulse
        ctl(8'hFF);
        check(ctl_rdata == 16'hC007, "R4 enable and mask", 64'(ctl_rdata), 64'hC007);
        check(intx_clr == 1'b1, "R10 pulse after enabling write", 64'(intx_clr), 64'd1);
        step();
        check(intx_clr == 1'b0, "R10 pulse lasts one cycle", 64'(intx_clr), 64'd0);
        ctl(8'h40);
        check(ctl_rdata == 16'h4007, "R4 mask only", 64'(ctl_rdata), 64'h4007);
        check(intx_clr == 1'b0, "R10 no pulse when disabling", 64'(intx_clr), 64'd0);
        ctl(8'h80);
        check(ctl_rdata == 16'h8007, "R4 enable only", 64'(ctl_rdata), 64'h8007);

        // Mark vectors 0..N-2 in use; the last stays unused
        for (int v = 0; v < N - 1; v++) use_step(4'(v), 1'b1);

        // R6: each unmasked vector sends, valid at the second edge
        for (int v = 0; v < N - 1; v++) begin
            req(4'(v));
            check(!msg_valid, "R6 not yet valid after one edge", 64'(msg_valid), 64'd0);
            step();
            check(msg_valid, "R6 valid after second edge", 64'(msg_valid), 64'd1);
            expect_msg(v, "R6 send");
        end

        // R7: unused vector and out-of-range vector
        req(4'(N - 1));
        expect_quiet("R7 unused vector");
        check_pend(32'd0, "R7 unused vector");
        req(4'(N + 1));
        expect_quiet("R7 out of range");
        check_pend(32'd0, "R7 out of range");

        // R5 and R8: vector mask and function mask park, unmask replays
        wr_reg(1'b0, 12'(2 * 16 + 12), 32'd1, 3'd4);
        req(4'd2);
        expect_quiet("R5 vector masked");
        check_pend(32'h0000_0004, "R5 vector masked");
        ctl(8'hC0);
        req(4'd3);
        expect_quiet("R5 function masked");
        check_pend(32'h0000_000C, "R5 function masked");
        ctl(8'h80);
        expect_msg(3, "R8 function unmask");
        expect_quiet("R8 vector two still masked");
        check_pend(32'h0000_0004, "R8 after function unmask");
        wr_reg(1'b0, 12'(2 * 16 + 12), 32'd0, 3'd4);
        expect_msg(2, "R8 table unmask");
        check_pend(32'd0, "R8 after table unmask");

        // R11: three parked vectors drain lowest first, held while stalled
        ctl(8'hC0);
        req(4'd5); req(4'd1); req(4'd4);
        check_pend(32'h0000_0032, "R11 parked set");
        ctl(8'h80);
        for (int i = 0; i < 16 && !msg_valid; i++) step();
        held = msg_addr;
        for (int i = 0; i < 3; i++) begin
            step();
            check(msg_valid && msg_addr == held, "R11 held while stalled", msg_addr, held);
        end
        expect_msg(1, "R11 first");
        expect_msg(4, "R11 second");
        expect_msg(5, "R11 third");
        expect_quiet("R11 drained");

        // R9: release on last decrement, decrement at zero is inert
        ctl(8'hC0);
        req(4'd6);
        check_pend(32'h0000_0040, "R9 parked");
        use_step(4'd6, 1'b0);
        check_pend(32'd0, "R9 release clears pending");
        use_step(4'd6, 1'b0);
        ctl(8'h80);
        expect_quiet("R9 nothing to replay");
        req(4'd6);
        expect_quiet("R9 count zero drops");
        use_step(4'd6, 1'b1);
        req(4'd6);
        expect_msg(6, "R9 count one after inert decrement");

        // R12: reset again after heavy use
        ctl(8'hC0);
        req(4'd0);
        rd_reg(1'b1, 12'h000, 3'd4, d0, e);
        check(d0 == 32'd1, "R5 parked before reset", 64'(d0), 64'd1);
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        check_reset_state("second reset");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule